// File: doc/BRIEF.md
# Strobe-Clocked Serial Bypass Port

This block is a bit-serial port that carries data only. It lets a host microcontroller swap raw bits with a radio baseband and skip the normal serializer/deserializer path. The block makes a strobe by dividing its own system clock, and the strobe is the bit clock of the port. Each strobe period carries exactly one pair of signals: a valid flag and a data bit. Because every bit carries its own flag, the port needs no separate clock and no framing.

In receive mode the baseband offers bits through a valid/ready stream. The block takes one bit on each falling strobe edge and drives it onto the data and flag lines, and the host samples those lines on the next rising edge. In transmit mode the block releases both lines so the host can drive them. On each falling strobe edge the block samples the lines and passes any flagged bit to the baseband through a one-entry hold. If a new flagged bit arrives while the hold is still occupied, the new bit is dropped and a sticky overflow flag is raised.

Top module: `bitstrobe_port`

## Requirements
- R1: During reset and after it, with the port disabled, `strobe_o` is 1 and `rx_rdy`, `tx_vld` and `ovf` are 0.
- R2: While `en` is 0 the strobe stays at 1 and its divider restarts. While `en` is 1 the strobe toggles once every `HALF_PER` clock cycles, so the first fall comes `HALF_PER` cycles after enable.
- R3: In receive mode (`tx_mode`=0) `rx_rdy` is 1 only in the single clock cycle that ends with a falling strobe edge, and a bit is accepted when `rx_vld` and `rx_rdy` are both 1. On that edge `dval` becomes 1 and `dio` takes the accepted bit. If `rx_vld` was 0, both lines become 0 and the slot carries no bit. The host sees the bits in order on rising strobe edges.
- R4: In receive mode the driven lines change only at a falling strobe edge. They are cleared to 0 whenever the port is not enabled in receive mode.
- R5: In transmit mode (`tx_mode`=1) the block does not drive `dio` or `dval`. On each falling strobe edge it samples both lines. If `dval` is 1, the bit appears on `tx_bit` with `tx_vld`=1 one cycle later. If `dval` is 0, the sample is ignored.
- R6: Once `tx_vld` is 1, it and `tx_bit` stay unchanged until a cycle with `tx_rdy`=1. That cycle delivers the bit and empties the hold.
- R7: A flagged bit sampled while the hold is full and not being delivered in the same cycle is dropped, and `ovf` becomes 1 and stays 1 until reset. If delivery and capture fall in the same cycle, the new bit is held and `ovf` does not change.
- R8: `rx_rdy` is never 1 in transmit mode or while the port is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Port enable; strobe runs only while high |
| tx_mode | input | 1 | 0 = receive (baseband to host), 1 = transmit (host to baseband) |
| rx_bit | input | 1 | Bit offered by the baseband |
| rx_vld | input | 1 | Baseband bit is present |
| rx_rdy | output | 1 | Block accepts the baseband bit this cycle |
| tx_bit | output | 1 | Held bit captured from the host |
| tx_vld | output | 1 | Hold contains a bit |
| tx_rdy | input | 1 | Baseband takes the held bit |
| ovf | output | 1 | Sticky overflow: a host bit was dropped |
| strobe_o | output | 1 | Bit strobe to the host, idle high |
| dio | inout | 1 | Serial data line |
| dval | inout | 1 | Per-bit valid line |

## Verification
In transmit mode, the baseband taking the held bit and the capture of a new flagged bit from the lines can happen in the same clock cycle. The bench provokes this with a phase in which the host flags every slot and `tx_rdy` is raised only in the cycle before each falling strobe edge. In that phase every capture lands on a hold that is being emptied. The run is judged by the per-cycle reference model agreeing on `tx_vld`, `tx_bit` and `ovf`, and by `ovf` still being 0 at the end of the phase. A later phase stalls `tx_rdy` so that the overflow case is reached.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   typedef enum logic {
      MODE_RX = 1'b0,
      MODE_TX = 1'b1
   } dir_e;

   typedef struct packed {
      logic v;
      logic d;
   } slot_t;

   localparam slot_t SLOT_EMPTY = '{v: 1'b0, d: 1'b0};
endpackage

// File: rtl/sbp_strobe_gen.sv
module sbp_strobe_gen #(
   parameter int unsigned HALF_PER = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic strobe,
   output logic fall_now
);
   localparam int unsigned CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

   logic s_q;
   assign strobe = s_q;

   generate
      if (HALF_PER == 1) begin : g_fast
         assign fall_now = en && s_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !en) s_q <= 1'b1;
            else               s_q <= ~s_q;
         end
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         logic          wrap;
         assign wrap     = (cnt_q == CW'(HALF_PER - 1));
         assign fall_now = en && wrap && s_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
               cnt_q <= '0;
               s_q   <= 1'b1;
            end else if (wrap) begin
               cnt_q <= '0;
               s_q   <= ~s_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbp_rx_launch.sv
module sbp_rx_launch
   import sbp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  act,
   input  logic  fall_now,
   input  logic  rx_bit,
   input  logic  rx_vld,
   output logic  rx_rdy,
   output slot_t line_q
);
   assign rx_rdy = act && fall_now;

   always_ff @(posedge clk) begin
      if (!rst_n || !act) begin
         line_q <= SLOT_EMPTY;
      end else if (fall_now) begin
         if (rx_vld) line_q <= '{v: 1'b1, d: rx_bit};
         else        line_q <= SLOT_EMPTY;
      end
   end
endmodule

// File: rtl/sbp_tx_capture.sv
module sbp_tx_capture
   import sbp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  act,
   input  logic  fall_now,
   input  slot_t line_in,
   output logic  tx_bit,
   output logic  tx_vld,
   input  logic  tx_rdy,
   output logic  ovf
);
   logic hold_v_q, hold_d_q, ovf_q;
   logic take, cap;

   assign take   = hold_v_q && tx_rdy;
   assign cap    = act && fall_now && line_in.v;
   assign tx_vld = hold_v_q;
   assign tx_bit = hold_d_q;
   assign ovf    = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v_q <= 1'b0;
         hold_d_q <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (cap) begin
         if (hold_v_q && !take) begin
            ovf_q <= 1'b1;
         end else begin
            hold_v_q <= 1'b1;
            hold_d_q <= line_in.d;
         end
      end else if (take) begin
         hold_v_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bitstrobe_port.sv
module bitstrobe_port
   import sbp_pkg::*;
#(
   parameter int unsigned HALF_PER = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tx_mode,
   input  logic rx_bit,
   input  logic rx_vld,
   output logic rx_rdy,
   output logic tx_bit,
   output logic tx_vld,
   input  logic tx_rdy,
   output logic ovf,
   output logic strobe_o,
   inout  wire  dio,
   inout  wire  dval
);
   generate
      if (HALF_PER < 1 || HALF_PER > 65535) begin : g_bad_half
         $error("bitstrobe_port: HALF_PER must lie in 1..65535");
      end
   endgenerate

   dir_e  dir;
   logic  act_rx, act_tx, fall_now;
   slot_t drv_line, smp_line;
   logic  drv_d, drv_v;

   assign dir    = dir_e'(tx_mode);
   assign act_rx = en && (dir == MODE_RX);
   assign act_tx = en && (dir == MODE_TX);

   sbp_strobe_gen #(.HALF_PER(HALF_PER)) u_stb (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .strobe   (strobe_o),
      .fall_now (fall_now)
   );

   sbp_rx_launch u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_rx),
      .fall_now (fall_now),
      .rx_bit   (rx_bit),
      .rx_vld   (rx_vld),
      .rx_rdy   (rx_rdy),
      .line_q   (drv_line)
   );

   assign drv_d = drv_line.d;
   assign drv_v = drv_line.v;
   assign dio   = act_rx ? drv_d : 1'bz;
   assign dval  = act_rx ? drv_v : 1'bz;

   assign smp_line = '{v: dval, d: dio};

   sbp_tx_capture u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_tx),
      .fall_now (fall_now),
      .line_in  (smp_line),
      .tx_bit   (tx_bit),
      .tx_vld   (tx_vld),
      .tx_rdy   (tx_rdy),
      .ovf      (ovf)
   );
endmodule

// File: rtl/sbp_checks.sv
module sbp_checks (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic tx_mode,
   input logic rx_rdy,
   input logic tx_bit,
   input logic tx_vld,
   input logic tx_rdy,
   input logic ovf,
   input logic strobe_o,
   input logic drv_d,
   input logic drv_v
);
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> strobe_o);

   a_r3_rdy_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rdy |=> $fell(strobe_o));

   a_r4_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en && !tx_mode) && !$fell(strobe_o)) |-> ($stable(drv_d) && $stable(drv_v)));

   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && !tx_rdy) |=> (tx_vld && $stable(tx_bit)));

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   a_r8_no_rdy_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode || !en) |-> !rx_rdy);
endmodule

bind bitstrobe_port sbp_checks u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .tx_mode  (tx_mode),
   .rx_rdy   (rx_rdy),
   .tx_bit   (tx_bit),
   .tx_vld   (tx_vld),
   .tx_rdy   (tx_rdy),
   .ovf      (ovf),
   .strobe_o (strobe_o),
   .drv_d    (drv_d),
   .drv_v    (drv_v)
);

// File: tb/sim_bitstrobe_port.sv
`timescale 1ns/1ps
module sim_bitstrobe_port;
   localparam int H = 3;

   logic clk = 1'b0;
   logic rst_n, en, tx_mode, rx_bit, rx_vld, tx_rdy;
   logic rx_rdy, tx_bit, tx_vld, ovf, strobe_o;
   logic h_d, h_v, h_oe;
   wire  dio, dval;

   always #4 clk = ~clk;

   assign h_oe = tx_mode;
   assign dio  = h_oe ? h_d : 1'bz;
   assign dval = h_oe ? h_v : 1'bz;

   bitstrobe_port #(.HALF_PER(H)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .tx_mode(tx_mode),
      .rx_bit(rx_bit), .rx_vld(rx_vld), .rx_rdy(rx_rdy),
      .tx_bit(tx_bit), .tx_vld(tx_vld), .tx_rdy(tx_rdy), .ovf(ovf),
      .strobe_o(strobe_o), .dio(dio), .dval(dval)
   );

   int n_chk = 0, n_fail = 0, ph = 0, n_take = 0, n_host = 0;
   bit done = 0;
   logic [15:0] lfsr = 16'hACE1;

   int m_cnt = 0;
   bit m_s = 1, m_ld = 0, m_lv = 0, m_hv = 0, m_hb = 0, m_ovf = 0;
   bit exp_q[$];
   bit prev_s = 1;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // behavioural reference model, updated on each rising clock
   always @(posedge clk) begin
      bit fall, act_rx, act_tx, hv;
      if (!rst_n) begin
         m_cnt = 0; m_s = 1; m_ld = 0; m_lv = 0;
         m_hv = 0; m_hb = 0; m_ovf = 0;
         exp_q.delete();
      end else begin
         fall   = en && (m_cnt == H - 1) && m_s;
         act_rx = en && !tx_mode;
         act_tx = en && tx_mode;
         hv     = h_oe ? h_v : 1'b0;
         if (!act_rx) begin
            m_ld = 0; m_lv = 0; exp_q.delete();
         end else if (fall) begin
            m_lv = rx_vld; m_ld = rx_vld ? rx_bit : 1'b0;
            if (rx_vld) exp_q.push_back(rx_bit);
         end
         if (m_hv && tx_rdy) begin m_hv = 0; n_take++; end
         if (act_tx && fall && hv) begin
            if (m_hv) m_ovf = 1;
            else begin m_hv = 1; m_hb = h_d; end
         end
         if (!en) begin m_cnt = 0; m_s = 1; end
         else if (m_cnt == H - 1) begin m_cnt = 0; m_s = !m_s; end
         else m_cnt++;
      end
   end

   // compare on every falling clock edge, then drive inputs
   always @(negedge clk) begin
      bit exp_rdy, rose, e;
      if (rst_n && !done) begin
         exp_rdy = en && !tx_mode && (m_cnt == H - 1) && m_s;
         chk("R2 strobe", strobe_o, m_s);
         chk(tx_mode ? "R8 rx_rdy in tx" : "R3 rx_rdy", rx_rdy, exp_rdy);
         if (en && !tx_mode) begin
            chk("R4 dio", dio, m_ld);
            chk("R4 dval", dval, m_lv);
         end
         if (en && tx_mode) chk("R5 dio released", dio, h_d);
         chk("R5 tx_vld", tx_vld, m_hv);
         if (m_hv) chk("R6 tx_bit", tx_bit, m_hb);
         chk("R7 ovf", ovf, m_ovf);
         rose = !prev_s && strobe_o;
         if (rose && en && !tx_mode && dval) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : !dio;
            chk("R3 host bit", dio, e);
            n_host++;
         end
         if (rose && tx_mode) begin
            h_v = (ph == 3) ? 1'b1 : (rnd() | rnd());
            h_d = rnd();
         end
      end
      prev_s = strobe_o;
      rx_vld = (ph == 1 || ph == 6) ? (rnd() | rnd()) : 1'b0;
      rx_bit = rnd();
      case (ph)
         3: tx_rdy = en && tx_mode && (m_cnt == H - 1) && m_s;
         4: tx_rdy = rnd();
         default: tx_rdy = 1'b0;
      endcase
   end

   task automatic mid(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      int t0;
      rst_n = 0; en = 0; tx_mode = 0; rx_bit = 0; rx_vld = 0; tx_rdy = 0;
      h_d = 0; h_v = 0;
      mid(4);
      chk("R1 strobe in reset", strobe_o, 1'b1);
      chk("R1 tx_vld in reset", tx_vld, 1'b0);
      chk("R1 ovf in reset", ovf, 1'b0);
      rst_n = 1;
      mid(3);
      chk("R1 rx_rdy idle", rx_rdy, 1'b0);
      chk("R1 strobe idle", strobe_o, 1'b1);

      ph = 1; en = 1;
      mid(H - 1);
      chk("R2 no fall before HALF_PER", strobe_o, 1'b1);
      mid(300);
      chk("R3 host received bits", n_host > 20, 1'b1);

      ph = 2; en = 0;
      mid(20);
      chk("R2 strobe parked high", strobe_o, 1'b1);
      chk("R8 no rdy while off", rx_rdy, 1'b0);

      ph = 3; tx_mode = 1; en = 1;
      t0 = n_take;
      mid(200);
      chk("R7 same-cycle take and capture, no ovf", ovf, 1'b0);
      chk("R5 bits delivered in lockstep", (n_take - t0) > 20, 1'b1);

      ph = 4;
      mid(200);
      ph = 5;
      mid(12 * H);
      chk("R7 stall sets ovf", ovf, 1'b1);
      chk("R6 hold kept under stall", tx_vld, 1'b1);

      ph = 6; tx_mode = 0;
      t0 = n_host;
      mid(120);
      chk("R3 rx resumes after tx", (n_host - t0) > 5, 1'b1);
      chk("R7 ovf still sticky", ovf, 1'b1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule